// File: doc/BRIEF.md
# Error Output Pulse and Polarity Formatter

This block turns two internal error summaries into output pins. One is the system-error summary and the other is the clock-error summary. Each channel has its own two-bit format setting. The setting picks one of four pin behaviours: a level that is active high, a level that is active low, a pulse that is active high, or a pulse that is active low. In the pulse formats, a rising edge of the error summary starts one pulse. The length of the pulse is set by a per-channel width value. The width is counted in ticks of a slow timebase, and that timebase reaches the block as a single-cycle enable strobe.

A routing select decides whether the active-low interrupt line also reports the system-error channel. The format and width values come from a register bank outside the block, and the error summaries come from error collection logic outside the block. The block only decides how each indication appears on its pins.

Top module: `errfmt_out`

## Requirements
- R1: Format encoding per channel: 2'b00 level active high, 2'b01 level active low, 2'b10 pulse active high, 2'b11 pulse active low. Bit 1 selects pulse and bit 0 selects low polarity. The pin equals the channel's internal active state XOR bit 0 of the current format.
- R2: In a level format, the internal active state equals the error input sampled on the previous clock edge.
- R3: In a pulse format with no pulse running, a rising edge of the error input (high now, low at the previous edge) makes the pin active from the next cycle.
- R4: A running pulse counts tick strobes. It ends on the clock edge where a tick arrives and the count already equals or exceeds the width value, so it spans width+1 ticks.
- R5: Rising edges of the error input that arrive while a pulse is running, including in its final cycle, neither restart nor extend it.
- R6: In the level formats the width value has no effect on the pin.
- R7: A change of a channel's format value cancels any pulse in progress on that edge. No new pulse starts on that edge.
- R8: During reset and right after it, each pin sits at its inactive level for the format presented: high for the low-polarity formats, low otherwise. The interrupt line is high.
- R9: With the routing select at 0, the active-low interrupt line stays high. With it at 1, the line is low exactly while the system-error channel is internally active.
- R10: The two channels are independent. Each uses only its own error input, format and width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase strobe that counts pulse width |
| sys_err_in | input | 1 | System-error summary |
| sys_fmt | input | 2 | System-error pin format (R1 encoding) |
| sys_width | input | CW | System-error pulse width, ticks minus one |
| clk_err_in | input | 1 | Clock-error summary |
| clk_fmt | input | 2 | Clock-error pin format (R1 encoding) |
| clk_width | input | CW | Clock-error pulse width, ticks minus one |
| route_sys_to_inta | input | 1 | 1 routes the system-error channel to the interrupt line |
| sys_err_out | output | 1 | Formatted system-error pin |
| clk_err_out | output | 1 | Formatted clock-error pin |
| inta_n | output | 1 | Active-low interrupt line |

## Verification
The bench builds the block with CW=4. This keeps every width value from 0 to the all-ones 15 reachable, so both the shortest pulse and the longest pulse occur within a few dozen ticks. The tick strobe is driven either at a fixed divide or at random, which places the end-of-pulse tick in every phase relative to new error edges and format changes.

// File: rtl/errfmt_pkg.sv
package errfmt_pkg;

  typedef enum logic [1:0] {
    FMT_LVL_HI = 2'b00,
    FMT_LVL_LO = 2'b01,
    FMT_PLS_HI = 2'b10,
    FMT_PLS_LO = 2'b11
  } fmt_e;

  function automatic logic fmt_is_pulse(input fmt_e f);
    return f[1];
  endfunction

  function automatic logic fmt_pin(input fmt_e f, input logic active);
    return active ^ f[0];
  endfunction

endpackage

// File: rtl/errfmt_pulse_timer.sv
module errfmt_pulse_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          enable,
  input  logic          cancel,
  input  logic          trig,
  input  logic [CW-1:0] width,
  output logic          busy
);

  logic          trig_q;
  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rise;

  assign rise = trig & ~trig_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (!enable || cancel) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (tick) begin
        if (cnt_q >= width) begin
          busy_d = 1'b0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end else if (rise) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      trig_q <= trig;
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;

endmodule

// File: rtl/errfmt_chan.sv
module errfmt_chan
  import errfmt_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          err,
  input  logic [1:0]    fmt,
  input  logic [CW-1:0] width,
  output logic          active,
  output logic          pin
);

  fmt_e fmt_cur, fmt_q;
  logic lvl_q;
  logic fmt_chg;
  logic pls_busy;

  assign fmt_cur = fmt_e'(fmt);
  assign fmt_chg = (fmt_cur != fmt_q);

  errfmt_pulse_timer #(.CW(CW)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .enable (fmt_is_pulse(fmt_cur)),
    .cancel (fmt_chg),
    .trig   (err),
    .width  (width),
    .busy   (pls_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      fmt_q <= FMT_LVL_HI;
    end else begin
      lvl_q <= err;
      fmt_q <= fmt_cur;
    end
  end

  assign active = fmt_is_pulse(fmt_cur) ? pls_busy : lvl_q;
  assign pin    = fmt_pin(fmt_cur, active);

endmodule

// File: rtl/errfmt_out.sv
module errfmt_out #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          sys_err_in,
  input  logic [1:0]    sys_fmt,
  input  logic [CW-1:0] sys_width,
  input  logic          clk_err_in,
  input  logic [1:0]    clk_fmt,
  input  logic [CW-1:0] clk_width,
  input  logic          route_sys_to_inta,
  output logic          sys_err_out,
  output logic          clk_err_out,
  output logic          inta_n
);

  localparam int NCH = 2;
  localparam int SYS = 0;
  localparam int CKE = 1;

  logic [NCH-1:0]         err_v;
  logic [NCH-1:0][1:0]    fmt_v;
  logic [NCH-1:0][CW-1:0] wid_v;
  logic [NCH-1:0]         act_v;
  logic [NCH-1:0]         pin_v;

  assign err_v[SYS] = sys_err_in;
  assign err_v[CKE] = clk_err_in;
  assign fmt_v[SYS] = sys_fmt;
  assign fmt_v[CKE] = clk_fmt;
  assign wid_v[SYS] = sys_width;
  assign wid_v[CKE] = clk_width;

  for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
    errfmt_chan #(.CW(CW)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .err    (err_v[gi]),
      .fmt    (fmt_v[gi]),
      .width  (wid_v[gi]),
      .active (act_v[gi]),
      .pin    (pin_v[gi])
    );
  end

  assign sys_err_out = pin_v[SYS];
  assign clk_err_out = pin_v[CKE];
  assign inta_n      = ~(route_sys_to_inta & act_v[SYS]);

endmodule

// File: rtl/errfmt_out_chk.sv
module errfmt_out_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          sys_err_in,
  input logic [1:0]    sys_fmt,
  input logic [CW-1:0] sys_width,
  input logic          route_sys_to_inta,
  input logic          sys_err_out,
  input logic          inta_n
);

  logic        up_q;
  logic [CW:0] ck_q;
  logic        sys_act;

  assign sys_act = sys_err_out ^ sys_fmt[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      ck_q <= '0;
    end else begin
      up_q <= 1'b1;
      if (sys_fmt[1] && sys_act) begin
        if (tick) ck_q <= ck_q + 1'b1;
      end else begin
        ck_q <= '0;
      end
    end
  end

  // R2: level formats show the error input one edge late
  a_r2_level_lag: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && !sys_fmt[1]) |-> (sys_act == $past(sys_err_in)));

  // R3: rising edge while idle in a stable pulse format starts a pulse
  a_r3_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && sys_fmt[1] && sys_fmt == $past(sys_fmt) && !sys_act
     && sys_err_in && !$past(sys_err_in)) |=> (!sys_fmt[1] || sys_act));

  // R4: the tick that reaches the width ends the pulse
  a_r4_pulse_end: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && sys_fmt[1] && sys_act && tick && ck_q >= {1'b0, sys_width})
    |=> (!sys_fmt[1] || !sys_act));

  // R7: a format change leaves no pulse running
  a_r7_fmt_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && sys_fmt != $past(sys_fmt)) |=> (!sys_fmt[1] || !sys_act));

  // R9: interrupt line off when not routed
  a_r9_inta_off: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && !route_sys_to_inta) |-> inta_n);

  // R9: interrupt line tracks the system channel when routed
  a_r9_inta_on: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && route_sys_to_inta) |-> (inta_n == !sys_act));

endmodule

bind errfmt_out errfmt_out_chk #(.CW(CW)) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .tick              (tick),
  .sys_err_in        (sys_err_in),
  .sys_fmt           (sys_fmt),
  .sys_width         (sys_width),
  .route_sys_to_inta (route_sys_to_inta),
  .sys_err_out       (sys_err_out),
  .inta_n            (inta_n)
);

// File: tb/errfmt_out_bench.sv
module errfmt_out_bench;

  localparam int CW     = 4;
  localparam int CLK_PD = 10;

  logic          clk;
  logic          rst_n;
  logic          tick;
  logic          route;
  logic [1:0]    err;
  logic [1:0]    fmt   [2];
  logic [CW-1:0] wid   [2];
  logic          sys_out, clk_out, inta_n;

  errfmt_out #(.CW(CW)) u_errfmt_out (
    .clk               (clk),
    .rst_n             (rst_n),
    .tick              (tick),
    .sys_err_in        (err[0]),
    .sys_fmt           (fmt[0]),
    .sys_width         (wid[0]),
    .clk_err_in        (err[1]),
    .clk_fmt           (fmt[1]),
    .clk_width         (wid[1]),
    .route_sys_to_inta (route),
    .sys_err_out       (sys_out),
    .clk_err_out       (clk_out),
    .inta_n            (inta_n)
  );

  int total, bad, cyc, tdiv;
  bit done;
  string tag;

  // requirement model state per channel
  logic       m_lvl  [2];
  logic       m_busy [2];
  int         m_cnt  [2];
  logic       m_prev [2];
  logic [1:0] m_fmtq [2];

  initial clk = 1'b0;
  always #(CLK_PD/2) clk = ~clk;

  function automatic logic exp_active(input int ch);
    return fmt[ch][1] ? m_busy[ch] : m_lvl[ch];
  endfunction

  function automatic logic exp_pin(input int ch);
    return exp_active(ch) ^ fmt[ch][0];
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_lvl[c] = 0; m_busy[c] = 0; m_cnt[c] = 0; m_prev[c] = 0; m_fmtq[c] = 2'b00;
    end
  endtask

  task automatic model_update();
    for (int c = 0; c < 2; c++) begin
      if (!fmt[c][1] || fmt[c] != m_fmtq[c]) begin
        m_busy[c] = 0; m_cnt[c] = 0;
      end else if (m_busy[c]) begin
        if (tick) begin
          if (m_cnt[c] >= int'(wid[c])) m_busy[c] = 0;
          else m_cnt[c] = m_cnt[c] + 1;
        end
      end else if (err[c] && !m_prev[c]) begin
        m_busy[c] = 1; m_cnt[c] = 0;
      end
      m_lvl[c]  = err[c];
      m_prev[c] = err[c];
      m_fmtq[c] = fmt[c];
    end
  endtask

  task automatic check(input string t, input logic act, input logic expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s at cycle %0d: got %b expected %b", t, cyc, act, expv);
    end
  endtask

  task automatic check_all();
    check({tag, " sys pin"}, sys_out, exp_pin(0));
    check({tag, " clk pin"}, clk_out, exp_pin(1));
    check({tag, " inta"}, inta_n, !(route && exp_active(0)));
  endtask

  task automatic step();
    if (tdiv == 0) tick = 1'($urandom % 2);
    else           tick = ((cyc % tdiv) == 0);
    @(posedge clk);
    model_update();
    #1;
    check_all();
    cyc++;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    void'($urandom(32'h5eed_2024));
    total = 0; bad = 0; cyc = 0; tdiv = 4; done = 0;
    rst_n = 0; tick = 0; route = 0; err = 2'b00;
    fmt[0] = 2'b01; fmt[1] = 2'b11; wid[0] = 4'd3; wid[1] = 4'd2;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R8: inactive levels during reset
    check("R8 sys pin in reset", sys_out, 1'b1);
    check("R8 clk pin in reset", clk_out, 1'b1);
    check("R8 inta in reset", inta_n, 1'b1);
    rst_n = 1;
    tag = "R8"; run(2);

    // R1, R2: level formats of both polarities
    tag = "R1"; fmt[0] = 2'b00; fmt[1] = 2'b01;
    err = 2'b11; run(2);
    check("R1 sys high level asserted", sys_out, 1'b1);
    check("R1 clk low level asserted", clk_out, 1'b0);
    tag = "R2";
    for (int i = 0; i < 20; i++) begin err = 2'($urandom); step(); end

    // R3, R4: single pulse of width 3, ticks every 4 clocks
    tag = "R3"; err = 2'b00; fmt[0] = 2'b10; fmt[1] = 2'b11; wid[0] = 4'd3; wid[1] = 4'd0;
    run(3);
    err = 2'b11; step();
    check("R3 sys pulse started", sys_out, 1'b1);
    check("R3 clk low pulse started", clk_out, 1'b0);
    tag = "R4"; run(30);
    check("R4 sys pulse ended", sys_out, 1'b0);

    // R4: longest width
    wid[0] = 4'd15; err = 2'b00; step(); err = 2'b01; tdiv = 2; run(40);

    // R5: retrigger during pulse
    tag = "R5"; tdiv = 3; wid[0] = 4'd5; err = 2'b00; step();
    for (int i = 0; i < 30; i++) begin err[0] = ~err[0]; step(); end

    // R6: width varies in level format
    tag = "R6"; fmt[0] = 2'b00; fmt[1] = 2'b01;
    for (int i = 0; i < 20; i++) begin wid[0] = 4'($urandom); wid[1] = 4'($urandom); err = 2'($urandom); step(); end

    // R7: polarity flip mid pulse cancels
    tag = "R7"; fmt[0] = 2'b10; wid[0] = 4'd8; err = 2'b00; run(2);
    err = 2'b01; run(3);
    fmt[0] = 2'b11; step();
    check("R7 sys pulse cancelled", sys_out, 1'b1);
    run(6);

    // R9: routing
    tag = "R9"; fmt[0] = 2'b00; route = 0; err = 2'b01; run(3);
    check("R9 unrouted inta high", inta_n, 1'b1);
    route = 1; step();
    check("R9 routed inta low", inta_n, 1'b0);
    err = 2'b00; run(2);
    check("R9 routed inta released", inta_n, 1'b1);

    // R10: random mix on both channels
    tag = "R10";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 8 == 0) err = 2'($urandom);
      if ($urandom % 60 == 0) fmt[0] = 2'($urandom);
      if ($urandom % 60 == 0) fmt[1] = 2'($urandom);
      if ($urandom % 40 == 0) wid[0] = 4'($urandom);
      if ($urandom % 40 == 0) wid[1] = 4'($urandom);
      if ($urandom % 50 == 0) route = 1'($urandom);
      if ($urandom % 300 == 0) tdiv = $urandom % 5;
      step();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got running expected finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule